// File: doc/BRIEF.md
# Masked-Access GPIO Register Bank

This block is an eight-pin general purpose I/O port behind a small word-addressed register window. A host issues single-cycle read or write strobes with a 12-bit byte offset and 32-bit data. The port holds the pin data, the per-pin direction, eight pad-configuration bytes, an analog-mode byte, an alternate-function select and a key-protected lock/commit pair. Every pin is driven from the block, and the external pin levels are sampled into the data register each clock for pins set as inputs.

The lower quarter of the window reaches the data register. The address itself carries a per-pin mask, so software can touch a subset of pins in one access without a read-modify-write. Alternate-function bits change only where a commit mask allows, and that mask can be rewritten only after a magic key has been written to the lock register. The top of the window returns fixed identification bytes. The data register is also exported so that a separate interrupt detector can watch the pin levels. The pad bytes are storage only.

Top module: `gpio_bank`

## Requirements
- R1: A read at an offset below 0x400 returns the data register ANDed with offset bits [9:2] in bits [7:0], with bits [31:8] zero.
- R2: A write at an offset below 0x400 changes only the data bits that are set both in offset bits [9:2] and in the direction register at 0x400 (1 = output). All other data bits of output pins keep their value.
- R3: Each pin output equals its data bit when the pin is an output and is 1 when the pin is an input.
- R4: For an input pin, the data bit takes the external pin level one clock after it is sampled. Pin level changes on output pins do not alter the data register.
- R5: Writing 0x0ACCE551 to 0x520 unlocks the port, and any other value locks it. A read of 0x520 returns 1 while locked and 0 while unlocked.
- R6: A write to the commit mask at 0x524 stores its low 8 bits only while the port is unlocked. While locked, the write has no effect.
- R7: A write to the alternate-function select at 0x420 updates only the bits whose commit-mask bit is 1. The register is driven on the `alt_sel` output.
- R8: After reset, the data, direction, alternate-function, pad and analog registers read 0, except that the 2 mA drive byte at 0x500 reads 0xFF, the lock reads 1 and the commit mask reads 0xFF.
- R9: The eight pad bytes at 0x500–0x51C (2 mA, 4 mA and 8 mA drive, open drain, pull-up, pull-down, slew, digital enable) and the analog byte at 0x528 store the low 8 bits of a write and read them back.
- R10: Offsets 0xFD0–0xFFC return one identification byte per word, index (offset−0xFD0)/4, from the table 00 00 00 00 61 00 18 01 0D F0 05 B1 (extended map) or 00 00 00 00 61 10 04 00 0D F0 05 B1 (base map).
- R11: Offsets from parameter `RESERVED_BASE` (0x52C extended, 0x424 base) up to 0xFCC read 0, and writes to them change no register.
- R12: Read data is registered. `rdata` shows the addressed value in the cycle after `rd_en` and holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 12 | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| pin_in | input | 8 | Sampled external pin levels |
| pin_out | output | 8 | Driven pin levels |
| pin_level | output | 8 | Data register, for the interrupt detector |
| alt_sel | output | 8 | Alternate-function select per pin |

## Verification
The assertions assume that `pin_in`, `addr` and the strobes are known and synchronous to `clk` after reset, and that each access lasts one cycle. They also assume that input pins can change in any cycle, so an input bit must always track the previous sample. The stimulus changes every input half a cycle away from the rising edge and holds the strobes for exactly one cycle. It moves `pin_in` both while the affected pins are inputs and while they are outputs, so the capture path and the path that ignores pin changes are both exercised.

// File: rtl/gpio_bank_pkg.sv
`timescale 1ns/1ps
package gpio_bank_pkg;
    localparam int PIN_N  = 8;
    localparam int ADDR_W = 12;
    localparam int BUS_W  = 32;
    localparam int PAD_N  = 8;
    localparam int PAD_IW = $clog2(PAD_N);
    localparam int ID_N   = 12;
    localparam int ID_IW  = $clog2(ID_N);

    localparam logic [ADDR_W-1:0] OFS_DIR    = 12'h400;
    localparam logic [ADDR_W-1:0] OFS_ALT    = 12'h420;
    localparam logic [ADDR_W-1:0] OFS_PAD0   = 12'h500;
    localparam logic [ADDR_W-1:0] OFS_LOCK   = 12'h520;
    localparam logic [ADDR_W-1:0] OFS_COMMIT = 12'h524;
    localparam logic [ADDR_W-1:0] OFS_ANALOG = 12'h528;
    localparam logic [ADDR_W-1:0] OFS_ID0    = 12'hFD0;
    localparam logic [BUS_W-1:0]  UNLOCK_KEY = 32'h0ACCE551;

    typedef enum logic [3:0] {
        K_NONE, K_DATA, K_DIR, K_ALT, K_PAD, K_ANALOG, K_LOCK, K_COMMIT, K_ID
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e          kind;
        logic [PIN_N-1:0]   pin_mask;
        logic [PAD_IW-1:0]  pad_idx;
        logic [ID_IW-1:0]   id_idx;
    } access_t;

    function automatic logic [7:0] pad_reset(input int k);
        return (k == 0) ? 8'hFF : 8'h00;
    endfunction

    function automatic logic [7:0] id_byte(input logic ext, input logic [ID_IW-1:0] idx);
        logic [7:0] b;
        case (idx)
            4'd4:    b = 8'h61;
            4'd5:    b = ext ? 8'h00 : 8'h10;
            4'd6:    b = ext ? 8'h18 : 8'h04;
            4'd7:    b = ext ? 8'h01 : 8'h00;
            4'd8:    b = 8'h0D;
            4'd9:    b = 8'hF0;
            4'd10:   b = 8'h05;
            4'd11:   b = 8'hB1;
            default: b = 8'h00;
        endcase
        return b;
    endfunction
endpackage

// File: rtl/gpio_addr_decode.sv
`timescale 1ns/1ps
module gpio_addr_decode
    import gpio_bank_pkg::*;
#(
    parameter logic [ADDR_W-1:0] RESERVED_BASE = 12'h52C
) (
    input  logic [ADDR_W-1:0] addr,
    output access_t           acc
);
    localparam logic [ADDR_W-1:0] RSVD_END = 12'hFCC;
    logic [ADDR_W-1:0] id_off;

    assign id_off = addr - OFS_ID0;

    always_comb begin
        acc          = '0;
        acc.kind     = K_NONE;
        acc.pin_mask = addr[PIN_N+1:2];
        acc.pad_idx  = addr[PAD_IW+1:2];
        acc.id_idx   = id_off[ID_IW+1:2];
        if (addr < OFS_DIR) begin
            acc.kind = K_DATA;
        end else if (addr > RSVD_END) begin
            acc.kind = (addr >= OFS_ID0) ? K_ID : K_NONE;
        end else if (addr >= RESERVED_BASE) begin
            acc.kind = K_NONE;
        end else if (addr[ADDR_W-1:2] == OFS_DIR[ADDR_W-1:2]) begin
            acc.kind = K_DIR;
        end else if (addr[ADDR_W-1:2] == OFS_ALT[ADDR_W-1:2]) begin
            acc.kind = K_ALT;
        end else if (addr[ADDR_W-1:PAD_IW+2] == OFS_PAD0[ADDR_W-1:PAD_IW+2]) begin
            acc.kind = K_PAD;
        end else if (addr[ADDR_W-1:2] == OFS_LOCK[ADDR_W-1:2]) begin
            acc.kind = K_LOCK;
        end else if (addr[ADDR_W-1:2] == OFS_COMMIT[ADDR_W-1:2]) begin
            acc.kind = K_COMMIT;
        end else if (addr[ADDR_W-1:2] == OFS_ANALOG[ADDR_W-1:2]) begin
            acc.kind = K_ANALOG;
        end
    end
endmodule

// File: rtl/gpio_pin_core.sv
`timescale 1ns/1ps
module gpio_pin_core
    import gpio_bank_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             data_wr,
    input  logic             dir_wr,
    input  logic [PIN_N-1:0] pin_mask,
    input  logic [PIN_N-1:0] wbyte,
    input  logic [PIN_N-1:0] pin_in,
    output logic [PIN_N-1:0] out_en_q,
    output logic [PIN_N-1:0] data_q,
    output logic [PIN_N-1:0] pin_out
);
    logic [PIN_N-1:0] wmask;
    logic [PIN_N-1:0] data_d;

    assign wmask  = data_wr ? (pin_mask & out_en_q) : '0;
    assign data_d = (data_q & out_en_q & ~wmask) | (wbyte & wmask) | (pin_in & ~out_en_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_en_q <= '0;
            data_q   <= '0;
        end else begin
            data_q <= data_d;
            if (dir_wr) out_en_q <= wbyte;
        end
    end

    for (genvar i = 0; i < PIN_N; i++) begin : g_pin
        assign pin_out[i] = out_en_q[i] ? data_q[i] : 1'b1;
    end

    // R4: input pins carry the previous pin sample
    assert_in_follow_R4: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((data_q ^ $past(pin_in)) & ~$past(out_en_q)) == '0);
    // R2: output data only moves on a data write
    assert_out_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && !$past(data_wr) |-> ((data_q ^ $past(data_q)) & $past(out_en_q)) == '0);
    // R2: unaddressed output bits never move
    assert_unmasked_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((data_q ^ $past(data_q)) & $past(out_en_q) & ~$past(pin_mask)) == '0);
endmodule

// File: rtl/gpio_alt_guard.sv
`timescale 1ns/1ps
module gpio_alt_guard
    import gpio_bank_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             lock_wr,
    input  logic             commit_wr,
    input  logic             alt_wr,
    input  logic [BUS_W-1:0] wdata,
    output logic             locked_q,
    output logic [PIN_N-1:0] commit_q,
    output logic [PIN_N-1:0] alt_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            locked_q <= 1'b1;
            commit_q <= '1;
            alt_q    <= '0;
        end else begin
            if (lock_wr) locked_q <= (wdata != UNLOCK_KEY);
            if (commit_wr && !locked_q) commit_q <= wdata[PIN_N-1:0];
            if (alt_wr) alt_q <= (alt_q & ~commit_q) | (wdata[PIN_N-1:0] & commit_q);
        end
    end

    // R6: commit mask frozen while locked
    assert_commit_locked_R6: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(locked_q) |-> commit_q == $past(commit_q));
    // R7: uncommitted select bits never move
    assert_alt_commit_R7: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((alt_q ^ $past(alt_q)) & ~$past(commit_q)) == '0);
endmodule

// File: rtl/gpio_pad_store.sv
`timescale 1ns/1ps
module gpio_pad_store
    import gpio_bank_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       pad_wr,
    input  logic [PAD_IW-1:0]          pad_idx,
    input  logic                       analog_wr,
    input  logic [7:0]                 wbyte,
    output logic [PAD_N-1:0][7:0]      pad_q,
    output logic [7:0]                 analog_q
);
    for (genvar k = 0; k < PAD_N; k++) begin : g_pad
        always_ff @(posedge clk) begin
            if (rst) pad_q[k] <= pad_reset(k);
            else if (pad_wr && pad_idx == PAD_IW'(k)) pad_q[k] <= wbyte;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) analog_q <= '0;
        else if (analog_wr) analog_q <= wbyte;
    end

    // R9: pad bytes hold without a pad write
    assert_pad_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && !$past(pad_wr) |-> $stable(pad_q));
endmodule

// File: rtl/gpio_bank.sv
`timescale 1ns/1ps
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter logic [11:0] RESERVED_BASE = 12'h52C
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [11:0] addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    input  logic [7:0]  pin_in,
    output logic [7:0]  pin_out,
    output logic [7:0]  pin_level,
    output logic [7:0]  alt_sel
);
    localparam logic EXT_MAP = (RESERVED_BASE > 12'h424);

    access_t              acc;
    logic [PIN_N-1:0]     out_en_q, data_q;
    logic                 locked_q;
    logic [PIN_N-1:0]     commit_q, alt_q;
    logic [PAD_N-1:0][7:0] pad_q;
    logic [7:0]           analog_q;
    logic [7:0]           rd_byte;

    gpio_addr_decode #(.RESERVED_BASE(RESERVED_BASE)) u_dec (
        .addr (addr),
        .acc  (acc)
    );

    gpio_pin_core u_pins (
        .clk      (clk),
        .rst      (rst),
        .data_wr  (wr_en && acc.kind == K_DATA),
        .dir_wr   (wr_en && acc.kind == K_DIR),
        .pin_mask (acc.pin_mask),
        .wbyte    (wdata[PIN_N-1:0]),
        .pin_in   (pin_in),
        .out_en_q (out_en_q),
        .data_q   (data_q),
        .pin_out  (pin_out)
    );

    gpio_alt_guard u_guard (
        .clk       (clk),
        .rst       (rst),
        .lock_wr   (wr_en && acc.kind == K_LOCK),
        .commit_wr (wr_en && acc.kind == K_COMMIT),
        .alt_wr    (wr_en && acc.kind == K_ALT),
        .wdata     (wdata),
        .locked_q  (locked_q),
        .commit_q  (commit_q),
        .alt_q     (alt_q)
    );

    gpio_pad_store u_pads (
        .clk       (clk),
        .rst       (rst),
        .pad_wr    (wr_en && acc.kind == K_PAD),
        .pad_idx   (acc.pad_idx),
        .analog_wr (wr_en && acc.kind == K_ANALOG),
        .wbyte     (wdata[7:0]),
        .pad_q     (pad_q),
        .analog_q  (analog_q)
    );

    always_comb begin
        unique case (acc.kind)
            K_DATA:   rd_byte = data_q & acc.pin_mask;
            K_DIR:    rd_byte = out_en_q;
            K_ALT:    rd_byte = alt_q;
            K_PAD:    rd_byte = pad_q[acc.pad_idx];
            K_ANALOG: rd_byte = analog_q;
            K_LOCK:   rd_byte = {7'd0, locked_q};
            K_COMMIT: rd_byte = commit_q;
            K_ID:     rd_byte = id_byte(EXT_MAP, acc.id_idx);
            default:  rd_byte = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) rdata <= '0;
        else if (rd_en) rdata <= {24'd0, rd_byte};
    end

    assign pin_level = data_q;
    assign alt_sel   = alt_q;

    // R12: read data holds between reads
    assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && !$past(rd_en) |-> $stable(rdata));
    // R1: upper read bits always zero
    assert_rdata_upper_R1: assert property (@(posedge clk) disable iff (rst)
        rdata[31:8] == 24'd0);
    // R3: input pins drive high
    assert_input_high_R3: assert property (@(posedge clk) disable iff (rst)
        (pin_out | out_en_q) == 8'hFF);
endmodule

// File: tb/gpio_bank_test.sv
`timescale 1ns/1ps
module gpio_bank_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [7:0]  pin_in = '0;
    logic [7:0]  pin_out, pin_level, alt_sel;

    int checks = 0, errors = 0;
    bit finished = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    gpio_bank uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
        .pin_level(pin_level), .alt_sel(alt_sel)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drain;
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    // monitor: a read strobe seen at an edge yields data by the next falling edge
    initial begin
        forever begin
            @(posedge clk);
            if (rd_en && !rst) begin
                @(negedge clk);
                chk(rdata, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        idle(3);
        @(negedge clk) rst = 1'b0;
        // R8 reset state
        chk({24'd0, pin_out}, 32'hFF, "R8 R3 pin_out after reset");
        bus_rd(12'h400, 32'h00, "R8 direction");
        bus_rd(12'h500, 32'hFF, "R8 2mA drive");
        bus_rd(12'h51C, 32'h00, "R8 digital enable");
        bus_rd(12'h520, 32'h01, "R8 R5 locked");
        bus_rd(12'h524, 32'hFF, "R8 commit");
        bus_rd(12'h420, 32'h00, "R8 alt select");
        // R4 input capture, R1 masked read
        pin_in = 8'hA5;
        idle(2);
        bus_rd(12'h3FC, 32'hA5, "R4 R1 full-mask read");
        bus_rd(12'h03C, 32'h05, "R1 low-nibble mask read");
        bus_rd(12'h204, 32'h81, "R1 sparse mask read");
        // R2 direction and masked writes, R3 outputs
        bus_wr(12'h400, 32'h0000_000F);
        bus_wr(12'h3FC, 32'hFFFF_FF3C);
        chk({24'd0, pin_out}, 32'hFC, "R3 mixed pins");
        chk({24'd0, pin_level}, 32'hAC, "R2 data after write");
        bus_wr(12'h00C, 32'h0000_00FF);
        bus_rd(12'h3FC, 32'hAF, "R2 two-bit masked write");
        bus_wr(12'h0C0, 32'h0000_0000);
        bus_rd(12'h3FC, 32'hAF, "R2 write to input pins ignored");
        pin_in = 8'h5A;
        idle(2);
        bus_rd(12'h3FC, 32'h5F, "R4 output pins ignore pin_in");
        chk({24'd0, pin_out}, 32'hFF, "R3 all high");
        bus_wr(12'h3FC, 32'h0000_0000);
        chk({24'd0, pin_out}, 32'hF0, "R3 outputs low");
        // R5 R6 R7 lock, commit, alt select
        bus_wr(12'h524, 32'h0000_0000);
        bus_rd(12'h524, 32'hFF, "R6 commit ignored while locked");
        bus_wr(12'h420, 32'hFFFF_FFFF);
        bus_rd(12'h420, 32'hFF, "R7 full commit");
        chk({24'd0, alt_sel}, 32'hFF, "R7 alt_sel port");
        bus_wr(12'h520, 32'h0ACC_E551);
        bus_rd(12'h520, 32'h00, "R5 unlocked by key");
        bus_wr(12'h524, 32'h1234_5633);
        bus_rd(12'h524, 32'h33, "R6 commit while unlocked");
        bus_wr(12'h520, 32'h0ACC_E550);
        bus_rd(12'h520, 32'h01, "R5 relocked by wrong key");
        bus_wr(12'h420, 32'h0000_0000);
        bus_rd(12'h420, 32'hCC, "R7 partial commit");
        bus_wr(12'h524, 32'h0000_00FF);
        bus_rd(12'h524, 32'h33, "R6 locked again");
        // R9 pad storage
        bus_wr(12'h504, 32'h0000_ABCD);
        bus_wr(12'h51C, 32'h0000_01FF);
        bus_wr(12'h528, 32'h0000_007E);
        bus_rd(12'h504, 32'hCD, "R9 4mA drive low byte");
        bus_rd(12'h51C, 32'hFF, "R9 digital enable");
        bus_rd(12'h528, 32'h7E, "R9 analog byte");
        bus_rd(12'h500, 32'hFF, "R9 neighbour untouched");
        // R10 identification
        bus_rd(12'hFD0, 32'h00, "R10 id 0");
        bus_rd(12'hFE0, 32'h61, "R10 id 4");
        bus_rd(12'hFE8, 32'h18, "R10 id 6");
        bus_rd(12'hFEC, 32'h01, "R10 id 7");
        bus_rd(12'hFFC, 32'hB1, "R10 id 11");
        // R11 reserved region
        bus_wr(12'h52C, 32'h0000_00FF);
        bus_wr(12'h600, 32'h0000_00FF);
        bus_rd(12'h52C, 32'h00, "R11 reserved start");
        bus_rd(12'h600, 32'h00, "R11 reserved middle");
        bus_rd(12'hFCC, 32'h00, "R11 reserved end");
        bus_rd(12'h528, 32'h7E, "R11 write ignored");
        bus_rd(12'h404, 32'h00, "R11 unmapped gap");
        // R12 hold without read strobe
        bus_rd(12'hFFC, 32'hB1, "R12 read");
        drain();
        bus_wr(12'h504, 32'h0000_0011);
        idle(2);
        chk(rdata, 32'hB1, "R12 rdata held");
        drain();
        idle(2);
        finish_run();
    end
endmodule